// File: doc/BRIEF.md
# System Interrupt Mask and Routing Register

This block is the system-wide front end of an interrupt controller. It samples 32 level-sensitive device interrupt lines into a pending word. A disable word gates each line, and software can only set disable bits through one register offset and only clear them through another. Both paths pass through a fixed mask of implemented bits, so bits outside the mask stay disabled forever. A 4-bit target field selects the one processor, out of 16, that receives hard interrupt requests.

Bit 31 of the disable word is a global kill. While it is set, no processor receives a request. Pending bit 31 is never set and always reads as zero. Software reaches the block through a word-indexed register port covering five words. Reads are registered. Writes take effect at the clock edge that accepts them. The pending word, the enabled-pending word, the kill flag, the target number and a one-hot per-processor request vector are also driven directly as outputs.

Top module: `irq_mask_route`

## Requirements
- R1: While reset is asserted and after it is released, the pending word is 0, the target is 0, the disable word holds 0x0FA2007F, the kill output is 0 and the read data is 0.
- R2: Each pending bit equals its input line one clock later. Input bits 23, 24, 25, 26 and 31 are ignored, so those pending bits are always 0.
- R3: A read of word index 0 returns the pending word with bit 31 forced to 0. All read data appears on `bus_rdata` one clock after the read strobe and holds until the next read. A read issued together with a write returns the value from before the write.
- R4: A read of word index 1 returns the disable word ANDed with 0xF05DFF80.
- R5: A write to word index 2 clears every disable bit where (write data AND 0xF05DFF80) has a 1 and leaves the other disable bits unchanged.
- R6: A write to word index 3 sets every disable bit where (write data AND 0xF05DFF80) has a 1. The pending word is not changed by this write.
- R7: A write to word index 4 stores the low 4 bits of the write data as the target. A read of index 4 returns the target zero-extended to 32 bits.
- R8: Disable bit 31 is the kill. `kill_o` shows it, and while it is 1 every bit of `cpu_req_o` is 0.
- R9: `eff_pend_o` equals the pending word ANDed with the inverted disable word, with no added register stage.
- R10: `cpu_req_o` is one-hot at the target index when `eff_pend_o` is nonzero and kill is 0. Otherwise it is all zero.
- R11: Reads of word indexes 5 to 7 return 0. Writes to them change no state.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Device interrupt line levels |
| bus_addr | input | 3 | Word index of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pend_o | output | 32 | Pending word |
| eff_pend_o | output | 32 | Pending word with disabled bits removed |
| kill_o | output | 1 | Global kill flag (disable bit 31) |
| target_o | output | 4 | Target processor number |
| cpu_req_o | output | 16 | One-hot hard interrupt request per processor |

## Verification
There are two timing classes of result. The pending word and the register state change at the first clock edge after a stimulus. Read data changes at the first edge after its read strobe. The enabled-pending word and the request vector change in the same cycle that the state they depend on changes, with no extra delay.

The bench drives every input at the falling edge. It then advances the model by exactly one rising edge and compares all outputs at the following falling edge. In this way, every check lands one edge after its stimulus, and the combinational results are compared against the state of that same cycle.

// File: rtl/irq_mask_route_pkg.sv
package irq_mask_route_pkg;

    localparam int          DATA_W    = 32;
    localparam int          ADDR_W    = 3;
    localparam int          KILL_BIT  = 31;
    // bits software may change in the disable word
    localparam logic [31:0] IMPL_MASK = 32'hF05DFF80;
    // disable word value after reset: every bit outside the implemented set
    localparam logic [31:0] DIS_RESET = ~IMPL_MASK;
    // input lines that have a level assigned (23..26 and 31 have none)
    localparam logic [31:0] SRC_LIVE  = 32'h787FFFFF;

    localparam logic [ADDR_W-1:0] IDX_PEND   = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_DIS    = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_ENABLE = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_MASK   = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_TGT    = 3'd4;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/irq_mr_src_latch.sv
module irq_mr_src_latch
    import irq_mask_route_pkg::*;
#(
    parameter int          NSRC = 32,
    parameter logic [NSRC-1:0] LIVE = SRC_LIVE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lines_i,
    output logic [NSRC-1:0] pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] sampled;

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        if (LIVE[g]) begin : g_live
            assign sampled[g] = lines_i[g];
        end else begin : g_dead
            assign sampled[g] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = sampled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2: lines with no level never show up as pending
    a_r2_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~LIVE) == '0);

    // R2: live lines are reflected one clock later
    a_r2_follow_line: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pend_o == ($past(lines_i) & LIVE));

endmodule

// File: rtl/irq_mr_mask_reg.sv
module irq_mr_mask_reg
    import irq_mask_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_stb_i,
    input  logic              set_stb_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] dis_o
);

    typedef struct packed {
        logic [DATA_W-1:0] dis;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] sel;

    assign sel = wdata_i & IMPL_MASK;

    always_comb begin
        st_d = st_q;
        if (clr_stb_i) st_d.dis = st_q.dis & ~sel;
        if (set_stb_i) st_d.dis = st_q.dis | sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.dis <= DIS_RESET;
        else        st_q     <= st_d;
    end

    assign dis_o = st_q.dis;

    // R1: bits outside the implemented set remain disabled
    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_o & ~IMPL_MASK) == ~IMPL_MASK);

    // R5: selected bits are cleared, others keep their value
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb_i |=> dis_o == ($past(dis_o) & ~($past(wdata_i) & IMPL_MASK)));

    // R6: selected bits are set, others keep their value
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> dis_o == ($past(dis_o) | ($past(wdata_i) & IMPL_MASK)));

    // R11: no strobe leaves the word alone
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_stb_i && !set_stb_i) |=> $stable(dis_o));

endmodule

// File: rtl/irq_mr_route.sv
module irq_mr_route
    import irq_mask_route_pkg::*;
#(
    parameter int NCPU  = 16,
    parameter int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_wr_i,
    input  logic [TGT_W-1:0]  tgt_wdata_i,
    input  logic [DATA_W-1:0] eff_i,
    input  logic              kill_i,
    output logic [TGT_W-1:0]  tgt_o,
    output logic [NCPU-1:0]   req_o
);

    typedef struct packed {
        logic [TGT_W-1:0] tgt;
    } st_t;

    st_t  st_d, st_q;
    logic deliver;

    always_comb begin
        st_d = st_q;
        if (tgt_wr_i) st_d.tgt = tgt_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_o   = st_q.tgt;
    assign deliver = (|eff_i) && !kill_i;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign req_o[c] = deliver && (st_q.tgt == TGT_W'(c));
    end

    // R7: the stored target is the written low bits
    a_r7_target: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_i |=> tgt_o == $past(tgt_wdata_i));

    // R10: at most one processor is asked
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_o));

    // R8: kill blocks every request
    a_r8_kill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |-> req_o == '0);

endmodule

// File: rtl/irq_mask_route.sv
module irq_mask_route
    import irq_mask_route_pkg::*;
#(
    parameter int NCPU  = 16,
    parameter int TGT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       irq_in,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       pend_o,
    output logic [31:0]       eff_pend_o,
    output logic              kill_o,
    output logic [TGT_W-1:0]  target_o,
    output logic [NCPU-1:0]   cpu_req_o
);

    localparam logic [DATA_W-1:0] PEND_VIS = ~(DATA_W'(1) << KILL_BIT);

    logic [DATA_W-1:0] pend_w, dis_w, eff_w, rd_val;
    logic              clr_stb, set_stb, tgt_stb;
    rd_state_t         rd_d, rd_q;

    assign clr_stb = bus_wr && (bus_addr == IDX_ENABLE);
    assign set_stb = bus_wr && (bus_addr == IDX_MASK);
    assign tgt_stb = bus_wr && (bus_addr == IDX_TGT);

    irq_mr_src_latch #(.NSRC(DATA_W), .LIVE(SRC_LIVE)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_in),
        .pend_o  (pend_w)
    );

    irq_mr_mask_reg u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_stb_i (clr_stb),
        .set_stb_i (set_stb),
        .wdata_i   (bus_wdata),
        .dis_o     (dis_w)
    );

    assign eff_w = pend_w & ~dis_w;

    irq_mr_route #(.NCPU(NCPU), .TGT_W(TGT_W)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgt_wr_i    (tgt_stb),
        .tgt_wdata_i (bus_wdata[TGT_W-1:0]),
        .eff_i       (eff_w),
        .kill_i      (dis_w[KILL_BIT]),
        .tgt_o       (target_o),
        .req_o       (cpu_req_o)
    );

    always_comb begin
        unique case (bus_addr)
            IDX_PEND: rd_val = pend_w & PEND_VIS;
            IDX_DIS:  rd_val = dis_w & IMPL_MASK;
            IDX_TGT:  rd_val = DATA_W'(target_o);
            default:  rd_val = '0;
        endcase
    end

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata  = rd_q.rdata;
    assign pend_o     = pend_w;
    assign eff_pend_o = eff_w;
    assign kill_o     = dis_w[KILL_BIT];

    // R3: read data holds between read strobes
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11: undefined indexes read back as zero
    a_r11_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > IDX_TGT) |=> bus_rdata == '0);

    // R9: disabled sources never appear as effective
    a_r9_eff_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_pend_o & dis_w) == '0 && (eff_pend_o & ~pend_o) == '0);

endmodule

// File: tb/irq_mask_route_tb_top.sv
`timescale 1ns/1ps
module irq_mask_route_tb_top;

    localparam logic [31:0] IMPL = 32'hF05DFF80;
    localparam logic [31:0] LIVE = 32'h787FFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pend_o, eff_pend_o;
    logic        kill_o;
    logic [3:0]  target_o;
    logic [15:0] cpu_req_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_pend, m_dis, m_rd;
    logic [3:0]  m_tgt;

    always #2 clk = ~clk;

    irq_mask_route dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pend_o(pend_o), .eff_pend_o(eff_pend_o),
        .kill_o(kill_o), .target_o(target_o), .cpu_req_o(cpu_req_o)
    );

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0:    return m_pend & 32'h7FFFFFFF;
            3'd1:    return m_dis & IMPL;
            3'd4:    return {28'b0, m_tgt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_req();
        if ((m_pend & ~m_dis) != 0 && !m_dis[31]) return 16'(1) << m_tgt;
        return 16'h0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 pending", pend_o, m_pend);
        chk("R9 effective", eff_pend_o, m_pend & ~m_dis);
        chk("R8 kill", {31'b0, kill_o}, {31'b0, m_dis[31]});
        chk("R7 target", {28'b0, target_o}, {28'b0, m_tgt});
        chk("R10 request", {16'b0, cpu_req_o}, {16'b0, exp_req()});
        chk("R3 rdata", bus_rdata, m_rd);
    endtask

    // drive at a falling edge, apply one rising edge, check at next falling edge
    task automatic step(logic [31:0] irq, logic wr, logic rd, logic [2:0] a,
                        logic [31:0] wd);
        irq_in = irq; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        if (rd) m_rd = exp_read(a);
        m_pend = irq & LIVE;
        if (wr) begin
            case (a)
                3'd2: m_dis = m_dis & ~(wd & IMPL);
                3'd3: m_dis = m_dis | (wd & IMPL);
                3'd4: m_tgt = wd[3:0];
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check_all();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_pend = '0; m_dis = 32'h0FA2007F; m_rd = '0; m_tgt = '0;
        irq_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(); // R1 during reset, inputs held high
        rst_n = 1'b1;
        irq_in = '0;
        // R1: disable readback after reset is zero
        step('0, 1'b0, 1'b1, 3'd1, '0);
        chk("R1 dis readback", bus_rdata, 32'h0);
        // R2: dead lines ignored
        step(32'hFFFFFFFF, 1'b0, 1'b1, 3'd0, '0);
        step(32'hFFFFFFFF, 1'b0, 1'b1, 3'd0, '0);
        chk("R3 pend readback", bus_rdata, 32'h787FFFFF);
        // R6: set all disables, pending unchanged, kill on
        step(32'hFFFFFFFF, 1'b1, 1'b0, 3'd3, 32'hFFFFFFFF);
        chk("R6 pend unchanged", pend_o, 32'h787FFFFF);
        chk("R8 kill set", {31'b0, kill_o}, 32'h1);
        step(32'hFFFFFFFF, 1'b0, 1'b1, 3'd1, '0);
        chk("R4 dis readback", bus_rdata, 32'hF05DFF80);
        // R5: clear everything except kill -> still no request
        step(32'hFFFFFFFF, 1'b1, 1'b0, 3'd2, 32'h7FFFFFFF);
        chk("R8 kill blocks", {16'b0, cpu_req_o}, 32'h0);
        // R7: target keeps low bits only
        step(32'h00000100, 1'b1, 1'b1, 3'd4, 32'hFFFFFF3B);
        chk("R3 read before write", bus_rdata, 32'h0);
        step(32'h00000100, 1'b1, 1'b0, 3'd2, 32'h80000000);
        chk("R10 req at target", {16'b0, cpu_req_o}, 32'h00000800);
        step(32'h00000100, 1'b0, 1'b1, 3'd4, '0);
        chk("R7 target readback", bus_rdata, 32'hB);
        // R11: undefined indexes
        step(32'h00000100, 1'b1, 1'b1, 3'd5, 32'hFFFFFFFF);
        chk("R11 undef read", bus_rdata, 32'h0);
        step(32'h00000100, 1'b1, 1'b0, 3'd6, 32'hFFFFFFFF);
        step(32'h00000100, 1'b1, 1'b0, 3'd7, 32'h0);
        chk("R11 no effect target", {28'b0, target_o}, 32'hB);
        chk("R11 no effect kill", {31'b0, kill_o}, 32'h0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            logic [31:0] irq;
            wd  = $urandom();
            irq = ($urandom() % 4 == 0) ? 32'h0 : $urandom() & $urandom();
            if ($urandom() % 3 != 0) wd[31] = 1'b0;
            step(irq, 1'($urandom()), 1'($urandom()), 3'($urandom()), wd);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule